// File: doc/BRIEF.md
# Three-Wire Serial Byte Memory Slave

This block is a 128-byte read/write memory that a host reaches over three wires: an enable line that frames each transfer, a serial clock, and one data line. The data line is split into an input, an output and an output-enable, so a pad or a bus model can make it bidirectional. All three serial inputs come from outside the system clock domain. Each one passes through a two-flop synchronizer and then an edge detector that runs on the system clock.

A transfer starts when the enable line rises. The host then clocks in a 24-bit command word, three bytes sent least-significant bit first:
- **Byte 1** selects write or read. It must match one of two exact codes.
- **Byte 2** holds a 7-bit address in bits 6..0. Bit 7 must be zero.
- **Byte 3** must have bits 6..0 at zero. Bit 7 requests burst mode.

Any mismatch in the command word locks the slave out until the enable line drops and rises again.

A valid command moves either one byte at the given address, or all 128 bytes starting at address 0 when the address is zero and the burst bit is set. Write bits are captured on rising serial-clock edges. Read bits are driven after falling serial-clock edges. Lowering the enable line ends any transfer and releases the data line.

Top module: `serial_ram_slave`

## Requirements
- R1: Write code 0x9D in byte 1 (bit 0 first: 1,0,1,1,1,0,0,1) makes the 8 data bits that follow the 24th command bit, sent LSB first, be stored at the address in byte 2 bits 6..0.
- R2: Read code 0x62 in byte 1 makes the stored byte at that address appear LSB first on `dq_o`. Bit k is driven after the falling serial-clock edge that precedes data clock k, and `dq_oe` is high while each bit is presented.
- R3: A byte 1 value other than 0x9D or 0x62 aborts the cycle. No memory location changes, `dq_oe` stays low until the enable line is cycled, and the next properly framed cycle works normally.
- R4: Byte 2 bit 7 set to 1 aborts the cycle with the same lockout as R3.
- R5: Any of byte 3 bits 6..0 set to 1 aborts the cycle with the same lockout as R3.
- R6: An address of zero with byte 3 bit 7 set selects burst mode. In burst mode, 128 consecutive bytes are written or read, starting at address 0 and incrementing.
- R7: A nonzero address with byte 3 bit 7 set is a single-byte transfer. In single-byte mode, clocks after the 8th data bit neither write memory nor enable the output.
- R8: Lowering the enable line ends a transfer at once. In a write burst, bytes not yet completed stay unchanged. After a read is cut off, `dq_oe` goes low.
- R9: After reset, and whenever the enable line is low, `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_en | input | 1 | Transfer enable from the host; a rising edge starts a cycle |
| ser_clk | input | 1 | Serial clock from the host |
| dq_i | input | 1 | Serial data from the host |
| dq_o | output | 1 | Serial read data toward the host |
| dq_oe | output | 1 | Output enable for the data line |

## Verification
The main function is driven with these patterns:
- Single-byte writes and reads at a low address and at the top address, which separates correct address decoding and bit order from stuck or reversed bits.
- A full burst write and read of a position-dependent pattern, which shows whether the address increments and where the burst ends.
- Command words that are each wrong in exactly one field (byte 1 code, byte 2 reserved bit, byte 3 reserved bits). These are followed by readback through a valid cycle, which tells an abort apart from a silently accepted write.
- Extra clocks after a single byte, and enable drops in the middle of a burst write and in the middle of a read. These separate proper termination from runaway sequencing.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2,
    ST_LOCK = 2'd3
  } srs_state_e;

  localparam logic [7:0] CODE_WRITE = 8'h9D;
  localparam logic [7:0] CODE_READ  = 8'h62;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d[i];
        s2_q <= s1_q;
      end
    end
    assign q[i] = s2_q;
  end
endmodule

// File: rtl/srs_mem.sv
module srs_mem #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
  end

  assign rdata = arr[raddr];
endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
  import srs_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int CMD_BYTES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_s,
  input  logic          sck_s,
  input  logic          din_s,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] mem_raddr,
  input  logic [DW-1:0] mem_rdata,
  output logic          dq_o,
  output logic          dq_oe,
  output logic          locked
);
  localparam int CMD_W = CMD_BYTES * 8;
  localparam int CNT_W = $clog2(CMD_W + 1);
  localparam int BIT_W = $clog2(DW);

  srs_state_e     state_q, state_d;
  logic           sck_d_q, en_d_q;
  logic [CMD_W-1:0] cmd_q, cmd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic           rd_q, rd_d, burst_q, burst_d;
  logic [DW-1:0]  byte_q, byte_d;
  logic           dout_q, dout_d, oe_q, oe_d;

  logic           rise, fall;
  logic [CMD_W-1:0] word;
  logic [7:0]     b1, b2, b3;
  logic           cmd_ok, cmd_rd, cmd_burst;
  logic [AW-1:0]  cmd_addr;
  logic [DW-1:0]  wbyte;
  logic           last_bit, last_addr;

  assign rise      = sck_s & ~sck_d_q;
  assign fall      = ~sck_s & sck_d_q;
  assign word      = {din_s, cmd_q[CMD_W-1:1]};
  assign b1        = word[7:0];
  assign b2        = word[15:8];
  assign b3        = word[23:16];
  assign cmd_rd    = (b1 == CODE_READ);
  assign cmd_ok    = ((b1 == CODE_WRITE) | cmd_rd) & ~b2[7] & (b3[6:0] == 7'd0);
  assign cmd_addr  = b2[AW-1:0];
  assign cmd_burst = (cmd_addr == '0) & b3[7];
  assign wbyte     = {din_s, byte_q[DW-1:1]};
  assign last_bit  = (cnt_q == CNT_W'(DW - 1));
  assign last_addr = (addr_q == '1);

  assign mem_raddr = (state_q == ST_CMD) ? cmd_addr : addr_q + AW'(1);
  assign mem_waddr = addr_q;
  assign mem_wdata = wbyte;

  always_comb begin
    state_d = state_q;
    cmd_d   = cmd_q;
    cnt_d   = cnt_q;
    addr_d  = addr_q;
    rd_d    = rd_q;
    burst_d = burst_q;
    byte_d  = byte_q;
    dout_d  = dout_q;
    oe_d    = oe_q;
    mem_we  = 1'b0;
    if (!en_s) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      dout_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_CMD;
          cnt_d   = '0;
        end
        ST_CMD: begin
          if (rise) begin
            cmd_d = word;
            cnt_d = cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(CMD_W - 1)) begin
              cnt_d = '0;
              if (cmd_ok) begin
                state_d = ST_DATA;
                addr_d  = cmd_addr;
                rd_d    = cmd_rd;
                burst_d = cmd_burst;
                byte_d  = mem_rdata;
              end else begin
                state_d = ST_LOCK;
              end
            end
          end
        end
        ST_DATA: begin
          if (fall && rd_q) begin
            dout_d = byte_q[cnt_q[BIT_W-1:0]];
            oe_d   = 1'b1;
          end
          if (rise) begin
            cnt_d = cnt_q + CNT_W'(1);
            if (!rd_q) byte_d = wbyte;
            if (last_bit) begin
              cnt_d  = '0;
              mem_we = ~rd_q;
              if (burst_q && !last_addr) begin
                addr_d = addr_q + AW'(1);
                if (rd_q) byte_d = mem_rdata;
              end else begin
                state_d = ST_LOCK;
                oe_d    = 1'b0;
              end
            end
          end
        end
        ST_LOCK: oe_d = 1'b0;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sck_d_q <= 1'b0;
      en_d_q  <= 1'b0;
      cmd_q   <= '0;
      cnt_q   <= '0;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      burst_q <= 1'b0;
      byte_q  <= '0;
      dout_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      sck_d_q <= sck_s;
      en_d_q  <= en_s;
      cmd_q   <= cmd_d;
      cnt_q   <= cnt_d;
      addr_q  <= addr_d;
      rd_q    <= rd_d;
      burst_q <= burst_d;
      byte_q  <= byte_d;
      dout_q  <= dout_d;
      oe_q    <= oe_d;
    end
  end

  assign dq_o   = dout_q;
  assign dq_oe  = oe_q;
  assign locked = (state_q == ST_LOCK);
endmodule

// File: rtl/serial_ram_slave.sv
module serial_ram_slave #(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int CMD_BYTES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_en,
  input  logic ser_clk,
  input  logic dq_i,
  output logic dq_o,
  output logic dq_oe
);
  logic          rst_a_q, rst_core_n;
  logic [2:0]    pins_s;
  logic          mem_we, locked;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_a_q    <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_a_q    <= 1'b1;
      rst_core_n <= rst_a_q;
    end
  end

  srs_sync #(.N(3)) sync_i (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     ({dq_i, ser_clk, ser_en}),
    .q     (pins_s)
  );

  srs_ctrl #(.AW(AW), .DW(DW), .CMD_BYTES(CMD_BYTES)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .en_s      (pins_s[0]),
    .sck_s     (pins_s[1]),
    .din_s     (pins_s[2]),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .mem_raddr (mem_raddr),
    .mem_rdata (mem_rdata),
    .dq_o      (dq_o),
    .dq_oe     (dq_oe),
    .locked    (locked)
  );

  srs_mem #(.AW(AW), .DW(DW)) mem_i (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );
endmodule

// File: rtl/srs_chk.sv
module srs_chk (
  input logic clk,
  input logic rst_n,
  input logic ser_en,
  input logic ser_clk,
  input logic dq_o,
  input logic dq_oe,
  input logic mem_we,
  input logic locked
);
  logic [2:0] age_q;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= 3'd0;
    else if (age_q != 3'd7) age_q <= age_q + 3'd1;
  end
  assign warm = (age_q >= 3'd4);

  // R9
  idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !ser_en && !$past(ser_en) && !$past(ser_en, 2) && !$past(ser_en, 3)) |-> !dq_oe);

  // R2
  dq_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && dq_oe && $past(dq_oe) && (dq_o != $past(dq_o))) |-> !$past(ser_clk, 2));

  // R3 R4 R5
  lock_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !mem_we);

  // R1
  single_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R8
  en_low_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !ser_en && !$past(ser_en) && !$past(ser_en, 2)) |-> !mem_we);
endmodule

bind serial_ram_slave srs_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .ser_en  (ser_en),
  .ser_clk (ser_clk),
  .dq_o    (dq_o),
  .dq_oe   (dq_oe),
  .mem_we  (mem_we),
  .locked  (locked)
);

// File: tb/serial_ram_slave_tb_top.sv
module serial_ram_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_en = 1'b0;
  logic ser_clk = 1'b1;
  logic dq_i = 1'b0;
  logic dq_o, dq_oe;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  serial_ram_slave dut_i (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops captured read bytes and compares against expectations.
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(g == e, t, g, e);
      end
    end
  end

  task automatic sbit(input logic d, output logic q, output logic oe);
    @(negedge clk);
    ser_clk = 1'b0;
    dq_i    = d;
    repeat (7) @(negedge clk);
    q  = dq_o;
    oe = dq_oe;
    ser_clk = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic open_cyc();
    @(negedge clk);
    ser_en = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic close_cyc();
    @(negedge clk);
    ser_en = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] c1, input logic [7:0] c2,
                          input logic [7:0] c3, output bit oe_any);
    logic [23:0] w;
    logic q, oe;
    w = {c3, c2, c1};
    oe_any = 0;
    for (int i = 0; i < 24; i++) begin
      sbit(w[i], q, oe);
      if (oe) oe_any = 1;
    end
  endtask

  task automatic xfer(input logic [7:0] wd, output logic [7:0] rd,
                      output bit oe_all, output bit oe_any);
    logic q, oe;
    oe_all = 1;
    oe_any = 0;
    for (int i = 0; i < 8; i++) begin
      sbit(wd[i], q, oe);
      rd[i] = q;
      if (oe) oe_any = 1; else oe_all = 0;
    end
  endtask

  task automatic wr_single(input logic [6:0] a, input logic [7:0] d, input bit flag);
    bit oa, ob;
    logic [7:0] r;
    open_cyc();
    send_cmd(8'h9D, {1'b0, a}, {flag, 7'd0}, ob);
    xfer(d, r, oa, ob);
    close_cyc();
  endtask

  task automatic rd_single(input logic [6:0] a, input logic [7:0] e, input string tag);
    bit oa, ob;
    logic [7:0] r;
    open_cyc();
    send_cmd(8'h62, {1'b0, a}, 8'd0, ob);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    xfer(8'h00, r, oa, ob);
    got_q.push_back(r);
    chk(oa, {tag, " oe high during read"}, oa, 1);
    close_cyc();
  endtask

  task automatic abort_write(input logic [7:0] c1, input logic [7:0] c2,
                             input logic [7:0] c3, input string tag);
    bit oa, ob, oc;
    logic [7:0] r;
    open_cyc();
    send_cmd(c1, c2, c3, oc);
    xfer(8'h00, r, oa, ob);
    chk(!(ob || oc), {tag, " oe during aborted cycle"}, ob, 0);
    close_cyc();
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit oa, ob;
    logic [7:0] r;
    logic q, oe;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R9 reset state
    chk(dq_oe == 1'b0, "R9 oe after reset", dq_oe, 0);

    // R1 / R2 single byte write then read
    wr_single(7'h10, 8'h5A, 1'b0);
    wr_single(7'h7F, 8'hC3, 1'b0);
    rd_single(7'h10, 8'h5A, "R1 R2 addr10");
    rd_single(7'h7F, 8'hC3, "R1 R2 addr7F");

    // R7 nonzero address with burst flag, extra clocks ignored
    wr_single(7'h21, 8'h22, 1'b0);
    open_cyc();
    send_cmd(8'h9D, 8'h20, 8'h80, ob);
    xfer(8'h11, r, oa, ob);
    xfer(8'hEE, r, oa, ob);
    close_cyc();
    rd_single(7'h20, 8'h11, "R7 flagged byte");
    rd_single(7'h21, 8'h22, "R7 neighbour untouched");
    open_cyc();
    send_cmd(8'h62, 8'h20, 8'h00, ob);
    xfer(8'h00, r, oa, ob);
    xfer(8'h00, r, oa, ob);
    chk(!ob, "R7 oe after 8th read bit", ob, 0);
    close_cyc();

    // R3 / R4 / R5 aborts
    wr_single(7'h30, 8'h33, 1'b0);
    abort_write(8'h9C, 8'h30, 8'h00, "R3");
    rd_single(7'h30, 8'h33, "R3 memory unchanged");
    abort_write(8'h63, 8'h30, 8'h00, "R3 bad read code");
    abort_write(8'h9D, 8'hB0, 8'h00, "R4");
    rd_single(7'h30, 8'h33, "R4 memory unchanged");
    abort_write(8'h9D, 8'h30, 8'h01, "R5");
    abort_write(8'h9D, 8'h30, 8'h40, "R5 bit6");
    rd_single(7'h30, 8'h33, "R5 memory unchanged");

    // R6 burst write then burst read
    open_cyc();
    send_cmd(8'h9D, 8'h00, 8'h80, ob);
    for (int i = 0; i < 128; i++) xfer(pat(i), r, oa, ob);
    close_cyc();
    open_cyc();
    send_cmd(8'h62, 8'h00, 8'h80, ob);
    for (int i = 0; i < 128; i++) begin
      exp_q.push_back(pat(i));
      tag_q.push_back($sformatf("R6 burst byte %0d", i));
      xfer(8'h00, r, oa, ob);
      got_q.push_back(r);
    end
    xfer(8'h00, r, oa, ob);
    chk(!ob, "R6 oe after 128 bytes", ob, 0);
    close_cyc();

    // R8 burst write cut short mid byte 5
    open_cyc();
    send_cmd(8'h9D, 8'h00, 8'h80, ob);
    for (int i = 0; i < 5; i++) xfer(8'hA0 + 8'(i), r, oa, ob);
    for (int i = 0; i < 3; i++) sbit(1'b1, q, oe);
    close_cyc();
    open_cyc();
    send_cmd(8'h62, 8'h00, 8'h80, ob);
    for (int i = 0; i < 7; i++) begin
      exp_q.push_back(i < 5 ? 8'hA0 + 8'(i) : pat(i));
      tag_q.push_back($sformatf("R8 burst cut byte %0d", i));
      xfer(8'h00, r, oa, ob);
      got_q.push_back(r);
    end
    for (int i = 0; i < 3; i++) sbit(1'b0, q, oe);
    chk(oe == 1'b1, "R8 oe before cut", oe, 1);
    close_cyc();
    chk(dq_oe == 1'b0, "R8 R9 oe after enable low", dq_oe, 0);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule